// File: doc/BRIEF.md
# Core Architectural State and Stack Unit

This block keeps the programmer-visible state of a small 8-bit Harvard microcontroller core: an accumulator, an index register, a stack pointer, a flag register and a 16-bit program counter. An instruction decoder outside the block drives an operation code and an 8-bit operand each cycle. The block then updates its registers and drives the RAM and register-space strobes for that operation. The RAM array and the peripheral register file sit outside the block. Both answer reads combinationally, in the same cycle as the request.

The stack lives in a 256-byte RAM page. A push stores at the stack pointer and then bumps it up by one. A pop first steps it down by one and then reads at the new value. The stack pointer wraps at both ends of the page. Register space is split into two 256-byte banks, and one bit of the flag register picks the bank. The flag register is itself visible at one fixed register address in both banks. Accesses to every other address leave on an external port whose 9-bit address carries the bank bit on top.

The program counter has its own controls: a sequential step and a jump with a target. A step that carries into the upper byte of the PC costs one extra cycle. During that cycle a stall output is high and the fetch address is held. A jump never pays this penalty.

Top module: `cpu_state_unit`

## Requirements
- R1: After reset, the accumulator, index register, stack pointer and PC read 0, the flag register reads 8'h02 (bit 1 is the zero flag, set), and stall is low.
- R2: OP_LOAD_A (code 1) and OP_LOAD_X (code 2) copy op_data into the accumulator or the index register at the next clock edge.
- R3: OP_PUSH_A (code 5) and OP_PUSH_X (code 6) assert ram_we with ram_addr equal to the current stack pointer and ram_wdata equal to the chosen register. The stack pointer then increments by one.
- R4: OP_POP_A (code 7) and OP_POP_X (code 8) decrement the stack pointer. They assert ram_re with ram_addr equal to the decremented value and load ram_rdata into the chosen register.
- R5: The stack pointer wraps from 8'hFF to 8'h00 on a push and from 8'h00 to 8'hFF on a pop, with no error indication.
- R6: OP_OR_F (code 3) ORs op_data into the flag register. Flag bit 4 is the bank select: 1 selects bank 1 and 0 selects bank 0.
- R7: OP_SWAP_A_SP (code 4) exchanges the accumulator and the stack pointer in one cycle.
- R8: OP_REG_RD (code 9) and OP_REG_WR (code 10) at register address 8'hF7 (given in op_data) read the flag register into the accumulator, or write the accumulator into the flag register. This works in either bank, and ext_req stays low.
- R9: Register accesses at any other address drive ext_req, with ext_addr = {flag bit 4, op_data}. A write also drives ext_we with ext_wdata equal to the accumulator. A read loads ext_rdata into the accumulator.
- R10: pc_step advances the PC by one in the next cycle when the low PC byte is not 8'hFF, including across 64-byte boundaries, with no stall.
- R11: pc_step with the low PC byte at 8'hFF raises stall for exactly one cycle while the PC is held. The PC then reaches the next 256-byte page.
- R12: pc_jump loads jump_addr into the PC at the next edge with no stall, wherever the target lies.
- R13: pc_step and pc_jump are ignored during the stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation code for this cycle |
| op_data | input | 8 | Immediate operand or register address |
| pc_step | input | 1 | Advance the PC sequentially |
| pc_jump | input | 1 | Load the PC from jump_addr |
| jump_addr | input | 16 | Jump target |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_re | output | 1 | Stack RAM read strobe |
| ram_addr | output | 8 | Stack RAM address |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_rdata | input | 8 | Stack RAM read data, same cycle |
| ext_req | output | 1 | External register access |
| ext_we | output | 1 | External register write |
| ext_addr | output | 9 | {bank bit, register address} |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, same cycle |
| acc_o | output | 8 | Accumulator |
| idx_o | output | 8 | Index register |
| sp_o | output | 8 | Stack pointer |
| flags_o | output | 8 | Flag register |
| pc_o | output | 16 | Program counter (fetch address) |
| stall_o | output | 1 | Page-crossing penalty cycle |

## Verification
Two situations are hard to reach from the ports: the stack pointer sitting at a page edge, and the PC sitting on a page's last byte. After reset the stack pointer only moves one step per push or pop. The bench therefore loads 8'hFF into the accumulator and swaps it into the stack pointer, which puts the wrap point one operation away in both directions. The PC is placed with a jump to an address ending in 8'hFE. A single step then puts it on the last byte, and the next step triggers the penalty. While the penalty cycle is in progress, the bench drives a conflicting jump and checks that it is ignored.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 16;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_LOAD_A    = 4'd1,
        OP_LOAD_X    = 4'd2,
        OP_OR_F      = 4'd3,
        OP_SWAP_A_SP = 4'd4,
        OP_PUSH_A    = 4'd5,
        OP_PUSH_X    = 4'd6,
        OP_POP_A     = 4'd7,
        OP_POP_X     = 4'd8,
        OP_REG_RD    = 4'd9,
        OP_REG_WR    = 4'd10
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] idx;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] flg;
        logic [PC_W-1:0]   pc;
        logic              stall;
    } arch_state_t;

endpackage

// File: rtl/cpu_stack_addr.sv
// Stack address generation: push uses SP then increments, pop decrements first.
module cpu_stack_addr #(
    parameter int SP_W = 8
) (
    input  logic [SP_W-1:0] sp,
    input  logic            is_pop,
    output logic [SP_W-1:0] sp_inc,
    output logic [SP_W-1:0] sp_dec,
    output logic [SP_W-1:0] mem_addr
);
    always_comb begin
        sp_inc   = sp + SP_W'(1);
        sp_dec   = sp - SP_W'(1);
        mem_addr = is_pop ? sp_dec : sp;
    end
endmodule

// File: rtl/cpu_reg_decode.sv
// Register-space decode: one address maps to the flag register in all banks.
module cpu_reg_decode #(
    parameter int              RA_W      = 8,
    parameter int              BANK_W    = 1,
    parameter logic [RA_W-1:0] FLAG_ADDR = 8'hF7
) (
    input  logic [RA_W-1:0]        addr,
    input  logic [BANK_W-1:0]      bank,
    output logic                   flag_hit,
    output logic [BANK_W+RA_W-1:0] ext_addr
);
    always_comb begin
        flag_hit = (addr == FLAG_ADDR);
        ext_addr = {bank, addr};
    end
endmodule

// File: rtl/cpu_pc_seq.sv
// PC sequencing with a one-cycle penalty when a step carries into the page byte.
module cpu_pc_seq #(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8
) (
    input  logic [PC_W-1:0] pc_q,
    input  logic            stall_q,
    input  logic            step,
    input  logic            jump,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc_d,
    output logic            stall_d
);
    logic page_end;

    always_comb begin
        page_end = &pc_q[PAGE_BITS-1:0];
        pc_d     = pc_q;
        stall_d  = 1'b0;
        if (stall_q) begin
            pc_d = pc_q + PC_W'(1);
        end else if (jump) begin
            pc_d = target;
        end else if (step) begin
            if (page_end) begin
                stall_d = 1'b1;
            end else begin
                pc_d = pc_q + PC_W'(1);
            end
        end
    end
endmodule

// File: rtl/cpu_state_unit.sv
module cpu_state_unit
    import cpu_state_pkg::*;
#(
    parameter int                DW        = cpu_state_pkg::DATA_W,
    parameter int                PW        = cpu_state_pkg::PC_W,
    parameter int                PAGE_BITS = 8,
    parameter logic [DW-1:0]     FLAG_ADDR = 8'hF7,
    parameter logic [DW-1:0]     FLAG_RST  = 8'h02,
    parameter int                BANK_BIT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] op_data,
    input  logic          pc_step,
    input  logic          pc_jump,
    input  logic [PW-1:0] jump_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic [DW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          ext_req,
    output logic          ext_we,
    output logic [DW:0]   ext_addr,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] idx_o,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] flags_o,
    output logic [PW-1:0] pc_o,
    output logic          stall_o
);
    localparam arch_state_t RST_STATE = '{acc: '0, idx: '0, sp: '0,
                                          flg: FLAG_RST, pc: '0, stall: 1'b0};

    arch_state_t st_q, st_d;
    op_e         op;

    logic          is_pop;
    logic [DW-1:0] sp_inc, sp_dec, stk_addr;
    logic          flag_hit;
    logic [DW:0]   dec_ext_addr;
    logic [PW-1:0] pc_nxt;
    logic          stall_nxt;

    assign op     = op_e'(op_code);
    assign is_pop = (op == OP_POP_A) || (op == OP_POP_X);

    cpu_stack_addr #(.SP_W(DW)) u_stack (
        .sp       (st_q.sp),
        .is_pop   (is_pop),
        .sp_inc   (sp_inc),
        .sp_dec   (sp_dec),
        .mem_addr (stk_addr)
    );

    cpu_reg_decode #(.RA_W(DW), .BANK_W(1), .FLAG_ADDR(FLAG_ADDR)) u_decode (
        .addr     (op_data),
        .bank     (st_q.flg[BANK_BIT]),
        .flag_hit (flag_hit),
        .ext_addr (dec_ext_addr)
    );

    cpu_pc_seq #(.PC_W(PW), .PAGE_BITS(PAGE_BITS)) u_pc (
        .pc_q    (st_q.pc),
        .stall_q (st_q.stall),
        .step    (pc_step),
        .jump    (pc_jump),
        .target  (jump_addr),
        .pc_d    (pc_nxt),
        .stall_d (stall_nxt)
    );

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = stk_addr;
        ram_wdata = '0;
        ext_req   = 1'b0;
        ext_we    = 1'b0;
        ext_addr  = dec_ext_addr;
        ext_wdata = st_q.acc;

        case (op)
            OP_LOAD_A:    st_d.acc = op_data;
            OP_LOAD_X:    st_d.idx = op_data;
            OP_OR_F:      st_d.flg = st_q.flg | op_data;
            OP_SWAP_A_SP: begin
                st_d.acc = st_q.sp;
                st_d.sp  = st_q.acc;
            end
            OP_PUSH_A, OP_PUSH_X: begin
                ram_we    = 1'b1;
                ram_wdata = (op == OP_PUSH_A) ? st_q.acc : st_q.idx;
                st_d.sp   = sp_inc;
            end
            OP_POP_A: begin
                ram_re   = 1'b1;
                st_d.acc = ram_rdata;
                st_d.sp  = sp_dec;
            end
            OP_POP_X: begin
                ram_re   = 1'b1;
                st_d.idx = ram_rdata;
                st_d.sp  = sp_dec;
            end
            OP_REG_RD: begin
                if (flag_hit) begin
                    st_d.acc = st_q.flg;
                end else begin
                    ext_req  = 1'b1;
                    st_d.acc = ext_rdata;
                end
            end
            OP_REG_WR: begin
                if (flag_hit) begin
                    st_d.flg = st_q.acc;
                end else begin
                    ext_req = 1'b1;
                    ext_we  = 1'b1;
                end
            end
            default: ;
        endcase

        st_d.pc    = pc_nxt;
        st_d.stall = stall_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign idx_o   = st_q.idx;
    assign sp_o    = st_q.sp;
    assign flags_o = st_q.flg;
    assign pc_o    = st_q.pc;
    assign stall_o = st_q.stall;

endmodule

// File: rtl/cpu_state_checker.sv
module cpu_state_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_code,
    input logic [7:0]  op_data,
    input logic        pc_jump,
    input logic [15:0] jump_addr,
    input logic        ram_we,
    input logic [7:0]  ram_addr,
    input logic        ext_req,
    input logic [8:0]  ext_addr,
    input logic [7:0]  acc_o,
    input logic [7:0]  sp_o,
    input logic [7:0]  flags_o,
    input logic [15:0] pc_o,
    input logic        stall_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_o == 8'h00 && sp_o == 8'h00 && flags_o == 8'h02
                    && pc_o == 16'h0 && !stall_o));

    p_push_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd5 || op_code == 4'd6) |-> (ram_we && ram_addr == sp_o));

    p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd5 || op_code == 4'd6) |=> sp_o == 8'($past(sp_o) + 8'd1));

    p_pop_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd7 || op_code == 4'd8) |=> sp_o == 8'($past(sp_o) - 8'd1));

    p_or_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd3 |=> (flags_o & $past(op_data)) == $past(op_data));

    p_flag_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> ext_addr[7:0] != 8'hF7);

    p_ext_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> ext_addr[8] == flags_o[4]);

    p_stall_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $stable(pc_o));

    p_jump_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_jump && !stall_o) |=> (pc_o == $past(jump_addr) && !stall_o));
endmodule

bind cpu_state_unit cpu_state_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .op_data   (op_data),
    .pc_jump   (pc_jump),
    .jump_addr (jump_addr),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ext_req   (ext_req),
    .ext_addr  (ext_addr),
    .acc_o     (acc_o),
    .sp_o      (sp_o),
    .flags_o   (flags_o),
    .pc_o      (pc_o),
    .stall_o   (stall_o)
);

// File: tb/cpu_state_unit_test.sv
module cpu_state_unit_test;
    import cpu_state_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [7:0]  op_data = 8'd0;
    logic        pc_step = 1'b0;
    logic        pc_jump = 1'b0;
    logic [15:0] jump_addr = 16'd0;
    logic        ram_we, ram_re, ext_req, ext_we, stall_o;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata, ext_wdata, ext_rdata;
    logic [8:0]  ext_addr;
    logic [7:0]  acc_o, idx_o, sp_o, flags_o;
    logic [15:0] pc_o;

    logic [7:0] ram_mem [256];
    logic [7:0] ext_mem [512];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cpu_state_unit uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_data(op_data),
        .pc_step(pc_step), .pc_jump(pc_jump), .jump_addr(jump_addr),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .acc_o(acc_o), .idx_o(idx_o), .sp_o(sp_o), .flags_o(flags_o),
        .pc_o(pc_o), .stall_o(stall_o)
    );

    assign ram_rdata = ram_mem[ram_addr];
    assign ext_rdata = ext_mem[ext_addr];

    always @(posedge clk) begin
        if (ram_we) ram_mem[ram_addr] <= ram_wdata;
        if (ext_req && ext_we) ext_mem[ext_addr] <= ext_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one operation for one cycle; registered results visible on return.
    task automatic run_op(input op_e op, input logic [7:0] data);
        @(negedge clk);
        op_code = op;
        op_data = data;
        @(negedge clk);
        op_code = OP_NOP;
        op_data = 8'h00;
    endtask

    task automatic t_reset;
        chk("R1 acc", acc_o, 0);
        chk("R1 idx", idx_o, 0);
        chk("R1 sp", sp_o, 0);
        chk("R1 flags", flags_o, 8'h02);
        chk("R1 pc", pc_o, 0);
        chk("R1 stall", stall_o, 0);
    endtask

    task automatic t_load;
        run_op(OP_LOAD_A, 8'h5A);
        chk("R2 load A", acc_o, 8'h5A);
        run_op(OP_LOAD_X, 8'hC3);
        chk("R2 load X", idx_o, 8'hC3);
    endtask

    task automatic t_push_pop;
        @(negedge clk);
        op_code = OP_PUSH_A;
        #1;
        chk("R3 push addr", ram_addr, 8'h00);
        chk("R3 push we", ram_we, 1);
        @(negedge clk);
        op_code = OP_NOP;
        chk("R3 push data", ram_mem[0], 8'h5A);
        chk("R3 push sp", sp_o, 8'h01);
        run_op(OP_PUSH_X, 8'h00);
        chk("R3 push X data", ram_mem[1], 8'hC3);
        chk("R3 push X sp", sp_o, 8'h02);
        @(negedge clk);
        op_code = OP_POP_A;
        #1;
        chk("R4 pop addr", ram_addr, 8'h01);
        chk("R4 pop re", ram_re, 1);
        @(negedge clk);
        op_code = OP_NOP;
        chk("R4 pop A", acc_o, 8'hC3);
        chk("R4 pop sp", sp_o, 8'h01);
        run_op(OP_POP_X, 8'h00);
        chk("R4 pop X", idx_o, 8'h5A);
        chk("R4 pop X sp", sp_o, 8'h00);
    endtask

    task automatic t_swap_wrap;
        run_op(OP_LOAD_A, 8'hFF);
        run_op(OP_SWAP_A_SP, 8'h00);
        chk("R7 swap sp", sp_o, 8'hFF);
        chk("R7 swap acc", acc_o, 8'h00);
        run_op(OP_LOAD_A, 8'h77);
        run_op(OP_PUSH_A, 8'h00);
        chk("R5 push at FF", ram_mem[255], 8'h77);
        chk("R5 push wrap", sp_o, 8'h00);
        run_op(OP_POP_X, 8'h00);
        chk("R5 pop wrap", sp_o, 8'hFF);
        chk("R5 pop data", idx_o, 8'h77);
    endtask

    task automatic t_flags;
        run_op(OP_OR_F, 8'h10);
        chk("R6 or flags", flags_o, 8'h12);
        run_op(OP_OR_F, 8'h00);
        chk("R6 or zero keeps", flags_o, 8'h12);
    endtask

    task automatic t_regspace;
        run_op(OP_LOAD_A, 8'h99);
        @(negedge clk);
        op_code = OP_REG_WR;
        op_data = 8'h20;
        #1;
        chk("R9 ext addr bank1", ext_addr, 9'h120);
        chk("R9 ext we", ext_we, 1);
        @(negedge clk);
        op_code = OP_NOP;
        chk("R9 write bank1", ext_mem[9'h120], 8'h99);
        chk("R9 bank0 untouched", ext_mem[9'h020], 8'h3C);
        run_op(OP_LOAD_A, 8'h11);
        @(negedge clk);
        op_code = OP_REG_WR;
        op_data = 8'hF7;
        #1;
        chk("R8 no ext on flag wr", ext_req, 0);
        @(negedge clk);
        op_code = OP_NOP;
        chk("R8 flag write bank1", flags_o, 8'h11);
        chk("R8 ext F7 untouched", ext_mem[9'h1F7], 8'h00);
        run_op(OP_LOAD_A, 8'h00);
        run_op(OP_REG_RD, 8'hF7);
        chk("R8 flag read bank1", acc_o, 8'h11);
        run_op(OP_LOAD_A, 8'h01);
        run_op(OP_REG_WR, 8'hF7);
        chk("R8 flag write to bank0", flags_o, 8'h01);
        run_op(OP_REG_RD, 8'h20);
        chk("R9 read bank0", acc_o, 8'h3C);
        run_op(OP_REG_RD, 8'hF7);
        chk("R8 flag read bank0", acc_o, 8'h01);
    endtask

    task automatic t_pc;
        @(negedge clk);
        pc_step = 1'b1;
        repeat (3) @(negedge clk);
        pc_step = 1'b0;
        chk("R10 three steps", pc_o, 16'h0003);
        @(negedge clk);
        pc_jump = 1'b1;
        jump_addr = 16'h003E;
        @(negedge clk);
        pc_jump = 1'b0;
        pc_step = 1'b1;
        repeat (2) @(negedge clk);
        pc_step = 1'b0;
        chk("R10 64-byte cross", pc_o, 16'h0040);
        chk("R10 no stall", stall_o, 0);
        pc_jump = 1'b1;
        jump_addr = 16'h01FE;
        @(negedge clk);
        pc_jump = 1'b0;
        pc_step = 1'b1;
        @(negedge clk);
        chk("R10 step to FF", pc_o, 16'h01FF);
        @(negedge clk);
        pc_step = 1'b1;
        pc_jump = 1'b1;
        jump_addr = 16'h5555;
        chk("R11 stall raised", stall_o, 1);
        chk("R11 pc held", pc_o, 16'h01FF);
        @(negedge clk);
        pc_step = 1'b0;
        pc_jump = 1'b0;
        chk("R13 ignore during stall", pc_o, 16'h0200);
        chk("R11 stall one cycle", stall_o, 0);
        pc_jump = 1'b1;
        jump_addr = 16'h02FF;
        @(negedge clk);
        jump_addr = 16'h0400;
        @(negedge clk);
        pc_jump = 1'b0;
        chk("R12 jump target", pc_o, 16'h0400);
        chk("R12 jump no stall", stall_o, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram_mem[i] = 8'h00;
        for (int i = 0; i < 512; i++) ext_mem[i] = 8'h00;
        ext_mem[9'h020] = 8'h3C;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_push_pop();
        t_swap_wrap();
        t_flags();
        t_regspace();
        t_pc();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule